// File: doc/BRIEF.md
# Flash Erase Request Validator

This block sits inside the command engine of a serial NOR flash. Each erase request carries a size code and a 24-bit byte address. The block checks the request against the current configuration: which sector map is active, where the small parameter sectors sit, and which range is write-protected. It then either accepts the request, giving the aligned start address and the byte length for the array sequencer, or rejects it.

A rejected request sets a sticky erase-error flag. A failure reported by the array sequencer sets the same flag. The host clears the flag with an explicit clear strobe.

Two sector maps are supported. The split map has sixteen 4 KB parameter sectors, forming a 64 KB region at the bottom or the top of the address space, with 64 KB sectors elsewhere. The uniform map has only 256 KB sectors. The legal erase sizes depend on which map is active. The two-sector (8 KB) erase code is never legal.

Top module: `erase_chk_top`

## Requirements
- R1: Size code 0 (4 KB) is accepted only when `cfg_uniform_i`=0 (split map) and the address lies in the parameter region. That region is 0x000000–0x00FFFF when `cfg_param_top_i`=0 and 0xFF0000–0xFFFFFF when it is 1. Any other 4 KB request is rejected.
- R2: Size code 2 (64 KB) is accepted at any address in the split map and is rejected in the uniform map (`cfg_uniform_i`=1). Applied inside the parameter region, it covers the whole 64 KB group of parameter sectors.
- R3: Size code 3 (256 KB) is accepted only in the uniform map and is rejected in the split map.
- R4: Size code 1 (8 KB) is rejected in every configuration.
- R5: For an accepted request, `res_start_o` is the address with its low bits cleared down to the erase-size boundary, and `res_len_o` is the size in bytes. For a rejected request, both are 0.
- R6: When `prot_en_i`=1 and `prot_lo_i`<=`prot_hi_i`, an otherwise legal request whose aligned range overlaps the inclusive range [`prot_lo_i`, `prot_hi_i`] is rejected.
- R7: A rejection sets `err_o` in the same cycle as its result. `seq_fail_i` high at a clock edge sets `err_o` from that edge on.
- R8: `err_o` stays set until `clr_err_i` is sampled high. A new accepted request does not clear it. If a set and a clear arrive at the same edge, the set wins.
- R9: A request is taken at an edge where `req_valid_i`=1 and `req_ready_o`=1, with `req_ready_o` = !`seq_busy_i`. `res_valid_o` pulses for one cycle right after the edge that took the request. No result follows an edge where `seq_busy_i`=1.
- R10: While reset is asserted, `res_valid_o`, `res_accept_o`, `res_start_o`, `res_len_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Erase request present |
| req_ready_o | output | 1 | Request can be taken (sequencer idle) |
| req_op_i | input | 2 | Size code: 0=4 KB, 1=8 KB, 2=64 KB, 3=256 KB |
| req_addr_i | input | 24 | Byte address of the request |
| cfg_uniform_i | input | 1 | 1 = uniform 256 KB map, 0 = split 4 KB + 64 KB map |
| cfg_param_top_i | input | 1 | 1 = parameter region at top, 0 = at bottom |
| prot_en_i | input | 1 | Protected-range descriptor is active |
| prot_lo_i | input | 24 | First protected byte address |
| prot_hi_i | input | 24 | Last protected byte address |
| seq_busy_i | input | 1 | Array sequencer is busy |
| seq_fail_i | input | 1 | Array sequencer reports an internal failure |
| clr_err_i | input | 1 | Clear the erase-error flag |
| res_valid_o | output | 1 | Result present (one-cycle pulse) |
| res_accept_o | output | 1 | Request accepted |
| res_start_o | output | 24 | Aligned start address of the erase |
| res_len_o | output | 19 | Erase length in bytes |
| err_o | output | 1 | Sticky erase-error flag |

## Verification
A wrong decision about size or map shows up as a wrong `res_accept_o` in the cycle right after the request was taken. The same cycle also shows a missing or extra rise of `err_o`. An alignment or protection-overlap fault appears in that same result cycle, as a wrong start or length or as an accept that should have been a reject. A corrupted sticky flag can stay hidden for many cycles. The reference model compares `err_o` on every clock, so a dropped or spurious bit is reported on the first cycle it differs, usually the cycle after the stray clear or set.

// File: rtl/erase_chk_pkg.sv
package erase_chk_pkg;
  typedef enum logic [1:0] {
    OP_4K   = 2'd0,
    OP_8K   = 2'd1,
    OP_64K  = 2'd2,
    OP_256K = 2'd3
  } erase_op_e;
endpackage

// File: rtl/erase_decode.sv
module erase_decode
  import erase_chk_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SUB_W     = 12,
  parameter int MID_W     = 16,
  parameter int BIG_W     = 18,
  parameter int PARAM_CNT = 16,
  localparam int LEN_W    = BIG_W + 1
) (
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              uniform_i,
  input  logic              param_top_i,
  output logic              legal_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int PREG_W = $clog2(PARAM_CNT) + SUB_W;
  localparam int HI_W   = ADDR_W - PREG_W;
  localparam logic [ADDR_W-1:0] MSK_SUB = {ADDR_W{1'b1}} << SUB_W;
  localparam logic [ADDR_W-1:0] MSK_MID = {ADDR_W{1'b1}} << MID_W;
  localparam logic [ADDR_W-1:0] MSK_BIG = {ADDR_W{1'b1}} << BIG_W;
  localparam logic [LEN_W-1:0]  LEN_SUB = LEN_W'(1) << SUB_W;
  localparam logic [LEN_W-1:0]  LEN_MID = LEN_W'(1) << MID_W;
  localparam logic [LEN_W-1:0]  LEN_BIG = LEN_W'(1) << BIG_W;

  logic [HI_W-1:0] hi_bits;
  logic            in_preg;
  erase_op_e       op;

  assign hi_bits = addr_i[ADDR_W-1:PREG_W];
  assign in_preg = param_top_i ? (&hi_bits) : ~(|hi_bits);
  assign op      = erase_op_e'(op_i);

  always_comb begin
    legal_o = 1'b0;
    start_o = '0;
    len_o   = '0;
    unique case (op)
      OP_4K: begin
        legal_o = !uniform_i && in_preg;
        start_o = addr_i & MSK_SUB;
        len_o   = LEN_SUB;
      end
      OP_64K: begin
        legal_o = !uniform_i;
        start_o = addr_i & MSK_MID;
        len_o   = LEN_MID;
      end
      OP_256K: begin
        legal_o = uniform_i;
        start_o = addr_i & MSK_BIG;
        len_o   = LEN_BIG;
      end
      default: legal_o = 1'b0; // two-sector erase never supported
    endcase
  end
endmodule

// File: rtl/erase_prot_cmp.sv
module erase_prot_cmp #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 19
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] last;
  logic              desc_ok;

  assign last    = start_i + ADDR_W'(len_i - LEN_W'(1));
  assign desc_ok = en_i && (lo_i <= hi_i);
  assign hit_o   = desc_ok && (start_i <= hi_i) && (last >= lo_i);
endmodule

// File: rtl/erase_status.sv
module erase_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic fail_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              err_q <= 1'b0;
    else if (set_i || fail_i) err_q <= 1'b1;
    else if (clr_i)           err_q <= 1'b0;
  end

  assign err_o = err_q;

  p_err_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || fail_i) |=> err_q);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
  p_err_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && !fail_i) |=> !err_q);
endmodule

// File: rtl/erase_chk_top.sv
module erase_chk_top
  import erase_chk_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SUB_W     = 12,
  parameter int MID_W     = 16,
  parameter int BIG_W     = 18,
  parameter int PARAM_CNT = 16,
  localparam int LEN_W    = BIG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              cfg_uniform_i,
  input  logic              cfg_param_top_i,
  input  logic              prot_en_i,
  input  logic [ADDR_W-1:0] prot_lo_i,
  input  logic [ADDR_W-1:0] prot_hi_i,
  input  logic              seq_busy_i,
  input  logic              seq_fail_i,
  input  logic              clr_err_i,
  output logic              res_valid_o,
  output logic              res_accept_o,
  output logic [ADDR_W-1:0] res_start_o,
  output logic [LEN_W-1:0]  res_len_o,
  output logic              err_o
);
  logic              take, legal, hit, accept, reject_now;
  logic [ADDR_W-1:0] dec_start;
  logic [LEN_W-1:0]  dec_len;

  logic              valid_q, acc_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;

  assign req_ready_o = !seq_busy_i;
  assign take        = req_valid_i && req_ready_o;

  erase_decode #(
    .ADDR_W(ADDR_W), .SUB_W(SUB_W), .MID_W(MID_W),
    .BIG_W(BIG_W), .PARAM_CNT(PARAM_CNT)
  ) i_decode (
    .op_i       (req_op_i),
    .addr_i     (req_addr_i),
    .uniform_i  (cfg_uniform_i),
    .param_top_i(cfg_param_top_i),
    .legal_o    (legal),
    .start_o    (dec_start),
    .len_o      (dec_len)
  );

  erase_prot_cmp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_prot (
    .en_i   (prot_en_i),
    .lo_i   (prot_lo_i),
    .hi_i   (prot_hi_i),
    .start_i(dec_start),
    .len_i  (dec_len),
    .hit_o  (hit)
  );

  assign accept     = legal && !hit;
  assign reject_now = take && !accept;

  erase_status i_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (reject_now),
    .fail_i(seq_fail_i),
    .clr_i (clr_err_i),
    .err_o (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
    end else begin
      valid_q <= take;
      acc_q   <= take && accept;
      if (take) begin
        start_q <= accept ? dec_start : '0;
        len_q   <= accept ? dec_len : '0;
      end
    end
  end

  assign res_valid_o  = valid_q;
  assign res_accept_o = acc_q;
  assign res_start_o  = start_q;
  assign res_len_o    = len_q;

  p_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(req_valid_i && !seq_busy_i));
  p_busy_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy_i |=> !res_valid_o);
  p_no_8k_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && req_op_i == 2'd1) |=> (res_valid_o && !res_accept_o));
  p_no_64k_uni_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cfg_uniform_i && req_op_i == 2'd2) |=> !res_accept_o);
  p_no_256k_split_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !cfg_uniform_i && req_op_i == 2'd3) |=> !res_accept_o);
  p_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_accept_o |-> ((res_start_o & ADDR_W'(res_len_o - LEN_W'(1))) == '0));
  p_rej_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_accept_o) |-> (res_start_o == '0 && res_len_o == '0));
  p_rej_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_accept_o) |-> err_o);
  p_prot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && hit) |=> !res_accept_o);
endmodule

// File: tb/test_erase_chk_top.sv
module test_erase_chk_top;
  localparam int CLK_PERIOD = 10;
  localparam int TOP_BASE   = 24'hFF0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [23:0] req_addr = '0;
  logic        cfg_uni = 1'b0, cfg_top = 1'b0;
  logic        pen = 1'b0;
  logic [23:0] plo = '0, phi = '0;
  logic        busy = 1'b0, fail = 1'b0, clr = 1'b0;

  logic        req_ready, res_valid, res_accept, err;
  logic [23:0] res_start;
  logic [18:0] res_len;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  bit    m_valid = 0, m_acc = 0, m_err = 0;
  int    m_start = 0, m_len = 0;
  string m_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_chk_top i_erase_chk_top (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr),
    .cfg_uniform_i(cfg_uni), .cfg_param_top_i(cfg_top),
    .prot_en_i(pen), .prot_lo_i(plo), .prot_hi_i(phi),
    .seq_busy_i(busy), .seq_fail_i(fail), .clr_err_i(clr),
    .res_valid_o(res_valid), .res_accept_o(res_accept),
    .res_start_o(res_start), .res_len_o(res_len), .err_o(err)
  );

  function automatic void ref_eval(input int op, input int a, input bit uni,
                                   input bit top, input bit pe, input int lo,
                                   input int hi, output bit ok, output int st,
                                   output int ln, output string tag);
    int  sz;
    bit  leg, in_p, ov;
    sz   = (op == 0) ? 4096 : (op == 1) ? 8192 : (op == 2) ? 65536 : 262144;
    in_p = top ? (a >= TOP_BASE) : (a < 65536);
    case (op)
      0: begin leg = !uni && in_p; tag = "R1"; end  // R1
      1: begin leg = 0;            tag = "R4"; end  // R4
      2: begin leg = !uni;         tag = "R2"; end  // R2
      default: begin leg = uni;    tag = "R3"; end  // R3
    endcase
    st = a - (a % sz);
    ov = pe && (lo <= hi) && (st <= hi) && (st + sz - 1 >= lo);  // R6
    if (leg && ov) tag = "R6";
    ok = leg && !ov;
    ln = ok ? sz : 0;
    if (!ok) st = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0; m_acc <= 0; m_start <= 0; m_len <= 0; m_err <= 0;
      m_tag <= "R10";
    end else begin
      bit ok; int st, ln; string tg;
      bit tk;
      tk = req_valid && !busy;
      m_valid <= tk;
      ok = 0; st = 0; ln = 0; tg = "R9";
      if (tk) begin
        ref_eval(int'(req_op), int'(req_addr), cfg_uni, cfg_top, pen,
                 int'(plo), int'(phi), ok, st, ln, tg);
        m_start <= st;
        m_len   <= ln;
        m_tag   <= tg;
      end
      m_acc <= tk && ok;
      if ((tk && !ok) || fail) m_err <= 1;  // R7, set wins over clear (R8)
      else if (clr) m_err <= 0;
    end
  end

  task automatic cmp(input string name, input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      string t;
      t = !rst_n ? "R10" : m_tag;
      cmp("req_ready", "R9", int'(req_ready), int'(!busy));
      cmp("res_valid", "R9", int'(res_valid), int'(m_valid));
      cmp("res_accept", t, int'(res_accept), int'(m_acc));
      cmp("res_start", rst_n ? "R5" : "R10", int'(res_start), m_start);
      cmp("res_len", rst_n ? "R5" : "R10", int'(res_len), m_len);
      cmp("err", rst_n ? "R8" : "R10", int'(err), int'(m_err));  // R7 R8
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; fail = 0; clr = 0;
    end
  endtask

  task automatic req(input logic [1:0] op, input logic [23:0] a);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; fail = 0; clr = 0;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    clr = 1; req_valid = 0;
    @(negedge clk);
    clr = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);  // R10 reset values compared here
    rst_n = 1;
    idle(2);
    // R1: split map, bottom parameter region
    req(2'd0, 24'h003ABC);
    req(2'd0, 24'h010000);      // outside region, reject
    clear_err();
    req(2'd0, 24'h00FFFF);
    cfg_top = 1;
    req(2'd0, 24'hFF5123);      // R1 top placement
    req(2'd0, 24'h000100);      // reject: now outside
    clear_err();
    // R2: 64 KB in split map, including parameter group
    req(2'd2, 24'hFF1234);
    req(2'd2, 24'h12ABCD);
    // R3: 256 KB rejected in split map
    req(2'd3, 24'h456789);
    clear_err();
    // R4: 8 KB always rejected
    req(2'd1, 24'hFF2000);
    clear_err();
    cfg_uni = 1;
    req(2'd1, 24'h000000);
    clear_err();
    req(2'd3, 24'h47FFFF);      // R3 accept
    req(2'd2, 24'h400000);      // R2 reject in uniform
    req(2'd0, 24'hFF0000);      // R1 reject in uniform
    clear_err();
    // R6: protection overlap
    pen = 1; plo = 24'h47FFFF; phi = 24'h480010;
    req(2'd3, 24'h440000);      // last byte 47FFFF hits
    clear_err();
    req(2'd3, 24'h500000);      // no overlap
    plo = 24'h600000; phi = 24'h100000;
    req(2'd3, 24'h000000);      // lo>hi descriptor ignored
    pen = 0;
    // R9: busy blocks requests
    @(negedge clk);
    busy = 1; req_valid = 1; req_op = 2'd3; req_addr = 24'h0;
    idle(0);
    @(negedge clk);
    req_valid = 0; busy = 0;
    idle(2);
    // R7: sequencer failure; R8: sticky through accepted request
    @(negedge clk); fail = 1;
    @(negedge clk); fail = 0;
    req(2'd3, 24'h800000);
    idle(2);
    // R8: clear and reject together, set wins
    @(negedge clk);
    clr = 1; req_valid = 1; req_op = 2'd1; req_addr = 24'h0;
    @(negedge clk);
    clr = 0; req_valid = 0;
    clear_err();
    idle(2);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      req_valid = ($urandom % 3) != 0;
      req_op    = 2'($urandom % 4);
      case ($urandom % 4)
        0: req_addr = 24'($urandom % 65536);
        1: req_addr = 24'(TOP_BASE + ($urandom % 65536));
        default: req_addr = 24'($urandom);
      endcase
      if (($urandom % 16) == 0) cfg_uni = ~cfg_uni;
      if (($urandom % 16) == 0) cfg_top = ~cfg_top;
      pen  = ($urandom % 2) == 1;
      plo  = 24'($urandom);
      phi  = 24'(int'(plo) + ($urandom % 24'h200000));
      busy = ($urandom % 5) == 0;
      fail = ($urandom % 23) == 0;
      clr  = ($urandom % 6) == 0;
    end
    @(negedge clk);
    req_valid = 0; busy = 0; fail = 0; clr = 0;
    idle(3);
    done = 1;
    summary();
  end
endmodule